// File: doc/BRIEF.md
# Radix-2 Booth Array Multiplier

This block multiplies two N-bit two's-complement operands in a single combinational pass. The multiplier operand is recoded into one signed digit per bit position (minus one, zero or plus one) by a column of small control cells. Each digit then steers one row of an array of configurable cells. A row either adds the multiplicand, subtracts it, or passes its incoming partial result through unchanged. Rows sit one weight apart, so row i applies its digit at weight 2^i. The array holds no state and has no feedback.

The array is trapezoidal. The first row spans 2N-1 bit positions and each following row spans one position fewer. The lowest bit a row produces is final, and the last row supplies the upper bits. The result is a (2N-1)-bit two's-complement product. That width holds every product except the one formed by the most negative operand multiplied by itself. The block is meant for datapaths that need a fixed-latency signed multiply with no clock, or as a leaf inside a larger pipelined unit.

Top module: `booth_array_mult`

## Requirements
- R1: A zero is placed below the least significant multiplier bit. Row i reads the bit pair (current = bit i, previous = bit i-1). The pair current=1, previous=0 selects subtract. The pair current=0, previous=1 selects add. The pairs 00 and 11 select skip. As examples, multiplier 0001 yields the multiplicand and multiplier 1111 yields its negation.
- R2: In an add row, the row's (2N-1)-bit result with its carry out equals the incoming partial result plus the sign-extended multiplicand shifted left by the row index. A subtract row gives the difference with its borrow out. A skip row passes the incoming partial result unchanged.
- R3: For every operand pair except most-negative times most-negative, `prod_o` equals the signed product of `mcand_i` and `mplier_i` as a (2N-1)-bit two's-complement value.
- R4: For N=4, multiplicand 1101 (-3) times multiplier 0101 (5) gives 1110001 (-15).
- R5: A zero multiplier gives a zero product for every multiplicand.
- R6: A negative multiplicand is sign-extended across the full product width, so negative times positive gives the correctly signed negative product.
- R7: Bit 0 of the product always equals the AND of bit 0 of each operand.
- R8: The block is purely combinational. A change on either operand reaches `prod_o` without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mcand_i | input | N | Signed multiplicand |
| mplier_i | input | N | Signed multiplier, recoded in bit pairs |
| prod_o | output | 2N-1 | Signed product |

## Verification
Each row owns exactly one final product bit. A wrong control code or a broken carry in row i therefore corrupts product bit i and usually bits above it. The fault shows at once, in the same evaluation as the operand change, with no latency to wait through. A recoding error shows as a product off by a multiple of the multiplicand shifted by the row index. A sign-extension fault shows only for negative multiplicands, and a borrow fault only where a subtract row is selected. For this reason the bench sweeps every operand pair at N=4 rather than sampling a few.

// File: rtl/booth_pkg.sv
package booth_pkg;

  // Row control: h = row active, d = subtract when active
  typedef struct packed {
    logic h;
    logic d;
  } ctrl_t;

  // Recode one multiplier bit pair into a row control
  function automatic ctrl_t booth_recode(input logic cur, input logic prev);
    ctrl_t c;
    c.h = cur ^ prev;
    c.d = cur & ~prev;
    return c;
  endfunction

  // Result bit of a multi-function cell
  function automatic logic cell_sum(input logic a, input logic b, input logic c,
                                    input ctrl_t ctl);
    return a ^ ((b ^ c) & ctl.h);
  endfunction

  // Carry (add) or borrow (subtract) out of a multi-function cell
  function automatic logic cell_carry(input logic a, input logic b, input logic c,
                                      input ctrl_t ctl);
    return ((a ^ ctl.d) & (b ^ c)) ^ (b & c);
  endfunction

endpackage

// File: rtl/booth_ctrl_cell.sv
module booth_ctrl_cell
  import booth_pkg::*;
(
  input  logic  cur_i,
  input  logic  prev_i,
  output ctrl_t ctl_o
);

  assign ctl_o = booth_recode(cur_i, prev_i);

endmodule

// File: rtl/booth_arith_cell.sv
module booth_arith_cell
  import booth_pkg::*;
(
  input  logic  a_i,
  input  logic  b_i,
  input  logic  c_i,
  input  ctrl_t ctl_i,
  output logic  z_o,
  output logic  c_o
);

  assign z_o = cell_sum(a_i, b_i, c_i, ctl_i);
  assign c_o = cell_carry(a_i, b_i, c_i, ctl_i);

endmodule

// File: rtl/booth_row.sv
module booth_row
  import booth_pkg::*;
#(
  parameter  int N   = 8,
  parameter  int ROW = 0,
  localparam int PW  = 2 * N - 1
) (
  input  logic [PW-1:0] acc_i,
  input  logic [N-1:0]  mcand_i,
  input  ctrl_t         ctl_i,
  output logic [PW-1:0] acc_o,
  output logic          carry_o
);

  // Ripple chain from the row's rightmost cell toward the top bit
  logic [PW:ROW] chain;

  assign chain[ROW] = 1'b0;
  assign carry_o    = chain[PW];

  for (genvar k = 0; k < PW; k++) begin : g_pos
    if (k < ROW) begin : g_hold
      // Bits below this row's weight are already final
      assign acc_o[k] = acc_i[k];
    end else begin : g_cell
      // Shifted multiplicand bit, sign-extended past its top bit
      localparam int BI = ((k - ROW) > (N - 1)) ? (N - 1) : (k - ROW);
      booth_arith_cell u_cell (
        .a_i   (acc_i[k]),
        .b_i   (mcand_i[BI]),
        .c_i   (chain[k]),
        .ctl_i (ctl_i),
        .z_o   (acc_o[k]),
        .c_o   (chain[k+1])
      );
    end
  end

endmodule

// File: rtl/booth_array_mult.sv
module booth_array_mult
  import booth_pkg::*;
#(
  parameter  int N  = 8,
  localparam int PW = 2 * N - 1
) (
  input  logic [N-1:0]  mcand_i,
  input  logic [N-1:0]  mplier_i,
  output logic [PW-1:0] prod_o
);

  // Multiplier with an implicit zero below its LSB
  logic [N:0]           mplier_ext;
  // Per-row control, partial-result chain and row carry/borrow outs
  ctrl_t [N-1:0]        row_ctl;
  logic [N:0][PW-1:0]   acc_chain;
  logic [N-1:0]         row_cout;

  assign mplier_ext   = {mplier_i, 1'b0};
  assign acc_chain[0] = '0;

  for (genvar i = 0; i < N; i++) begin : g_row
    booth_ctrl_cell u_ctrl (
      .cur_i  (mplier_ext[i+1]),
      .prev_i (mplier_ext[i]),
      .ctl_o  (row_ctl[i])
    );

    booth_row #(.N(N), .ROW(i)) u_row (
      .acc_i   (acc_chain[i]),
      .mcand_i (mcand_i),
      .ctl_i   (row_ctl[i]),
      .acc_o   (acc_chain[i+1]),
      .carry_o (row_cout[i])
    );
  end

  assign prod_o = acc_chain[N];

endmodule

// File: rtl/booth_array_mult_chk.sv
module booth_array_mult_chk
  import booth_pkg::*;
#(
  parameter  int N  = 8,
  localparam int PW = 2 * N - 1
) (
  input logic [N-1:0]        mcand_i,
  input logic [N-1:0]        mplier_i,
  input logic [PW-1:0]       prod_o,
  input ctrl_t [N-1:0]       row_ctl,
  input logic [N:0][PW-1:0]  acc_chain,
  input logic [N-1:0]        row_cout
);

  logic [N:0]              xe;
  logic signed [2*N-1:0]   full;
  logic                    both_min;

  assign xe       = {mplier_i, 1'b0};
  assign full     = $signed(mcand_i) * $signed(mplier_i);
  assign both_min = (mcand_i == {1'b1, {(N-1){1'b0}}}) &&
                    (mplier_i == {1'b1, {(N-1){1'b0}}});

  always_comb begin
    for (int i = 0; i < N; i++) begin
      automatic logic [PW-1:0] ysh;
      automatic logic [PW:0]   add_w;
      automatic logic [PW:0]   sub_w;
      ysh   = {{(PW-N){mcand_i[N-1]}}, mcand_i} << i;
      add_w = {1'b0, acc_chain[i]} + {1'b0, ysh};
      sub_w = {1'b0, acc_chain[i]} - {1'b0, ysh};
      AST_SUB_ONLY_ON_ONE_ZERO: assert (!row_ctl[i].d || (row_ctl[i].h && xe[i+1] && !xe[i])); // R1
      AST_ADD_ONLY_ON_ZERO_ONE: assert (!(row_ctl[i].h && !row_ctl[i].d) || (!xe[i+1] && xe[i])); // R1
      AST_SKIP_PASSES: assert (row_ctl[i].h || (acc_chain[i+1] == acc_chain[i])); // R2
      AST_ROW_ADD: assert (!(row_ctl[i].h && !row_ctl[i].d) || ({row_cout[i], acc_chain[i+1]} == add_w)); // R2
      AST_ROW_SUB: assert (!(row_ctl[i].h && row_ctl[i].d) || ({row_cout[i], acc_chain[i+1]} == sub_w)); // R2
    end
    AST_NO_OVERFLOW: assert (both_min || (prod_o == full[PW-1:0] && full[2*N-1] == full[PW-1])); // R3
    AST_PRODUCT_LSB: assert (prod_o[0] == (mcand_i[0] & mplier_i[0])); // R7
  end

endmodule

bind booth_array_mult booth_array_mult_chk #(.N(N)) u_chk (
  .mcand_i   (mcand_i),
  .mplier_i  (mplier_i),
  .prod_o    (prod_o),
  .row_ctl   (row_ctl),
  .acc_chain (acc_chain),
  .row_cout  (row_cout)
);

// File: tb/booth_array_mult_tb_top.sv
`timescale 1ns/1ps
module booth_array_mult_tb_top;

  localparam int N  = 4;
  localparam int PW = 2 * N - 1;

  logic          clk = 1'b0;
  logic [N-1:0]  mcand;
  logic [N-1:0]  mplier;
  logic [PW-1:0] prod;
  int            n_tests = 0;
  int            n_fail  = 0;
  bit            done    = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  booth_array_mult #(.N(N)) dut_i (
    .mcand_i  (mcand),
    .mplier_i (mplier),
    .prod_o   (prod)
  );

  task automatic check(input string req, input logic [PW-1:0] got,
                       input logic [PW-1:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: y=%b x=%b got %b expected %b", req, mcand, mplier, got, exp);
    end
  endtask

  // Drive on the falling edge, sample 2 ns later
  task automatic apply(input int y, input int x);
    @(negedge clk);
    mcand  = y[N-1:0];
    mplier = x[N-1:0];
    #2;
  endtask

  function automatic logic [PW-1:0] ref_mul(input int y, input int x);
    int p;
    p = y * x;
    return p[PW-1:0];
  endfunction

  initial begin
    mcand  = '0;
    mplier = '0;
    // R5: zero operands at start
    apply(0, 0);
    check("R5", prod, '0);

    // R4: worked example -3 * 5 = 1110001
    apply(-3, 5);
    check("R4", prod, 7'b1110001);

    // R1: multiplier 0001 -> sub row 0, add row 1 -> multiplicand
    apply(3, 1);
    check("R1", prod, 7'd3);
    // R1: multiplier 1111 -> sub row 0, remaining skip -> negation
    apply(3, -1);
    check("R1", prod, 7'h7d);
    // R1: multiplier 0110 -> add/sub mix: rows 1 sub, 3 add
    apply(5, 6);
    check("R1", prod, 7'd30);

    // R6: negative multiplicand, positive multiplier
    apply(-7, 7);
    check("R6", prod, ref_mul(-7, 7));
    apply(-8, 1);
    check("R6", prod, 7'h78);

    // R5: zero multiplier for every multiplicand
    for (int y = -8; y < 8; y++) begin
      apply(y, 0);
      check("R5", prod, '0);
    end

    // R3 and R7: every pair except most-negative squared
    for (int y = -8; y < 8; y++) begin
      for (int x = -8; x < 8; x++) begin
        if (!(y == -8 && x == -8)) begin
          apply(y, x);
          check("R3", prod, ref_mul(y, x));
          n_tests++;
          if (prod[0] !== (mcand[0] & mplier[0])) begin
            n_fail++;
            $display("FAIL R7: got %b expected %b", prod[0], mcand[0] & mplier[0]);
          end
        end
      end
    end

    // R8: change inputs away from any clock edge, result follows
    @(posedge clk);
    #1;
    mcand  = 4'd6;
    mplier = 4'd7;
    #1;
    check("R8", prod, 7'd42);
    mplier = 4'b1101;
    #1;
    check("R8", prod, ref_mul(6, -3));

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule